// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block overlays a 32x32 two-colour pointer onto a stream of display pixels. Software programs the shape and the placement through a word-wide register port. The shape is held as 32 transparency rows and 32 colour-select rows. The placement is one packed word that carries both coordinates. A miscellaneous control word sits on the same port. It holds whatever is written to it, and it always reports one status bit as set.

The pixel side takes one pixel per cycle: a valid flag, its column, its row and its base colour. The block decides whether the cursor covers that pixel. Where the cursor is transparent or absent, the base colour passes through unchanged. Where it is opaque, one of two overlay colours replaces the base colour. The overlay colours come in on input ports, because palette storage lives elsewhere. The result leaves one cycle later with its valid flag and coordinates.

Register writes act at once. The pixel presented in the cycle after a write already sees the new value, so a write during active video may tear the cursor for one frame.

Top module: `cur_overlay`

## Requirements
- R1: After reset, both cursor coordinates are 0xF000 and every shape row is 0, so no pixel is altered. The miscellaneous word reads 0x02000000.
- R2: A write to offset 0x8FC sets the cursor column from data bits 31:16 and the cursor row from data bits 15:0.
- R3: A write to offset 0x900+4*r loads transparency row r, and a write to 0x980+4*r loads colour-select row r, for r in 0..31.
- R4: The cursor covers screen rows Y to Y+31 and screen columns X to X+31, with no wrap at the coordinate limit. Bit 31 of shape row (y-Y) belongs to column X, and each lower bit belongs to the next column to its right.
- R5: Where a covered pixel's transparency bit is 0, its colour is unchanged. Where that bit is 1, the output colour is ovl_b_i if the colour-select bit is 1 and ovl_a_i if it is 0.
- R6: A pixel whose column is at or beyond disp_width_i is never altered. When X is at or beyond disp_width_i, the cursor draws nothing.
- R7: A write to offset 0x818 stores the data word. Reading 0x818 returns the stored word with bit 25 forced to 1.
- R8: Reads from every offset other than 0x818 return 0, including the position and shape offsets.
- R9: An access whose byte enables are not all four set is ignored: a write changes no state, and a read returns 0.
- R10: Each pixel's valid flag, column, row and resulting colour appear on the outputs exactly one cycle after they are presented.
- R11: A pixel presented in the cycle after a register write is composited with the written value. A pixel presented in the same cycle as the write uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| disp_width_i | input | 16 | Active display width in pixels |
| ovl_a_i | input | COLOR_W | Overlay colour used where the colour-select bit is 0 |
| ovl_b_i | input | COLOR_W | Overlay colour used where the colour-select bit is 1 |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 16 | Input pixel column |
| pix_y_i | input | 16 | Input pixel row |
| pix_color_i | input | COLOR_W | Input base colour |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_x_o | output | 16 | Output pixel column |
| pix_y_o | output | 16 | Output pixel row |
| pix_color_o | output | COLOR_W | Composited colour |

## Verification
The first pattern is a raster scan that covers the whole cursor with a margin on every side. The shape rows are loaded with distinct, irregular words, so that a swapped row, a reversed bit order or an off-by-one window edge each yields a wrong colour at a known spot. A second scan runs with the cursor straddling the right edge of the display, and a third with the cursor placed wholly past that edge. These two scans separate clipping by pixel column from suppression by cursor column. Single-cycle cases cover the rest: a write issued in the same cycle as a covered pixel, partial-byte-enable writes and reads, and reads of every named offset. These show when writes take effect and what the read port returns.

// File: rtl/cur_ovl_pkg.sv
package cur_ovl_pkg;
  localparam int unsigned DIM      = 32;
  localparam int unsigned ROW_W    = $clog2(DIM);
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned COORD_W  = 16;
  localparam int unsigned BE_W     = DATA_W / 8;

  localparam logic [ADDR_W-1:0]  OFF_MISC  = 12'h818;
  localparam logic [ADDR_W-1:0]  OFF_POS   = 12'h8FC;
  localparam logic [ADDR_W-1:0]  OFF_MASK  = 12'h900;
  localparam logic [ADDR_W-1:0]  OFF_SEL   = 12'h980;
  localparam logic [ADDR_W-1:0]  ROWS_SPAN = ADDR_W'(DIM * 4);
  localparam int unsigned        MISC_SET_BIT = 25;
  localparam logic [COORD_W-1:0] PARK_POS  = 16'hF000;
endpackage

// File: rtl/cur_ovl_regs.sv
module cur_ovl_regs
  import cur_ovl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [COORD_W-1:0] cur_x_o,
  output logic [COORD_W-1:0] cur_y_o,
  output logic [DATA_W-1:0]  mask_o [DIM],
  output logic [DATA_W-1:0]  sel_o  [DIM]
);
  logic              full_acc;
  logic              wr;
  logic              in_mask, in_sel;
  logic [ADDR_W-1:0] mask_off, sel_off;
  logic [ROW_W-1:0]  mask_row, sel_row;
  logic [DATA_W-1:0] misc_q;

  assign full_acc = &be_i;
  assign wr       = we_i & full_acc;
  assign mask_off = addr_i - OFF_MASK;
  assign sel_off  = addr_i - OFF_SEL;
  assign in_mask  = (addr_i >= OFF_MASK) && (mask_off < ROWS_SPAN);
  assign in_sel   = (addr_i >= OFF_SEL)  && (sel_off  < ROWS_SPAN);
  assign mask_row = mask_off[ROW_W+1:2];
  assign sel_row  = sel_off[ROW_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_x_o <= PARK_POS;
      cur_y_o <= PARK_POS;
      misc_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFF_POS) begin
        cur_x_o <= wdata_i[DATA_W-1 -: COORD_W];
        cur_y_o <= wdata_i[COORD_W-1:0];
      end
      if (addr_i == OFF_MISC) misc_q <= wdata_i;
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[r] <= '0;
        sel_o[r]  <= '0;
      end else if (wr) begin
        if (in_mask && mask_row == ROW_W'(r)) mask_o[r] <= wdata_i;
        if (in_sel  && sel_row  == ROW_W'(r)) sel_o[r]  <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (full_acc && addr_i == OFF_MISC) begin
      rdata_o = misc_q;
      rdata_o[MISC_SET_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/cur_ovl_hit.sv
module cur_ovl_hit
  import cur_ovl_pkg::*;
(
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [DATA_W-1:0]  mask_i [DIM],
  input  logic [DATA_W-1:0]  sel_i  [DIM],
  output logic               hit_o,
  output logic               pick_b_o
);
  localparam logic [COORD_W:0] SPAN = (COORD_W+1)'(DIM);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(DIM - 1);

  logic [COORD_W:0]  dx, dy;
  logic              in_x, in_y;
  logic [ROW_W-1:0]  row, col;
  logic [DATA_W-1:0] mrow, srow;

  // 17-bit differences: a negative offset sets the top bit and fails the span test
  assign dx   = {1'b0, pix_x_i} - {1'b0, cur_x_i};
  assign dy   = {1'b0, pix_y_i} - {1'b0, cur_y_i};
  assign in_x = (dx < SPAN) && (pix_x_i < width_i);
  assign in_y = (dy < SPAN);
  assign row  = dy[ROW_W-1:0];
  assign col  = LAST - dx[ROW_W-1:0];
  assign mrow = mask_i[row];
  assign srow = sel_i[row];

  assign hit_o    = in_x & in_y & mrow[col];
  assign pick_b_o = srow[col];
endmodule

// File: rtl/cur_ovl_blend.sv
module cur_ovl_blend
  import cur_ovl_pkg::*;
#(
  parameter int unsigned COLOR_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COLOR_W-1:0] color_i,
  input  logic [COLOR_W-1:0] ovl_a_i,
  input  logic [COLOR_W-1:0] ovl_b_i,
  input  logic               hit_i,
  input  logic               pick_b_i,
  output logic               valid_o,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic [COLOR_W-1:0] color_o
);
  logic [COLOR_W-1:0] mixed;

  always_comb begin
    mixed = color_i;
    if (hit_i) mixed = pick_b_i ? ovl_b_i : ovl_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      color_o <= '0;
    end else begin
      valid_o <= valid_i;
      x_o     <= x_i;
      y_o     <= y_i;
      color_o <= mixed;
    end
  end
endmodule

// File: rtl/cur_overlay.sv
module cur_overlay
  import cur_ovl_pkg::*;
#(
  parameter int unsigned COLOR_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_be_i,
  input  logic [11:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [15:0]        disp_width_i,
  input  logic [COLOR_W-1:0] ovl_a_i,
  input  logic [COLOR_W-1:0] ovl_b_i,
  input  logic               pix_valid_i,
  input  logic [15:0]        pix_x_i,
  input  logic [15:0]        pix_y_i,
  input  logic [COLOR_W-1:0] pix_color_i,
  output logic               pix_valid_o,
  output logic [15:0]        pix_x_o,
  output logic [15:0]        pix_y_o,
  output logic [COLOR_W-1:0] pix_color_o
);
  logic [COORD_W-1:0] cur_x, cur_y;
  logic [DATA_W-1:0]  mask [DIM];
  logic [DATA_W-1:0]  sel  [DIM];
  logic               hit, pick_b;

  cur_ovl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .be_i    (reg_be_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cur_x_o (cur_x),
    .cur_y_o (cur_y),
    .mask_o  (mask),
    .sel_o   (sel)
  );

  cur_ovl_hit u_hit (
    .pix_x_i  (pix_x_i),
    .pix_y_i  (pix_y_i),
    .width_i  (disp_width_i),
    .cur_x_i  (cur_x),
    .cur_y_i  (cur_y),
    .mask_i   (mask),
    .sel_i    (sel),
    .hit_o    (hit),
    .pick_b_o (pick_b)
  );

  cur_ovl_blend #(.COLOR_W(COLOR_W)) u_blend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (pix_valid_i),
    .x_i      (pix_x_i),
    .y_i      (pix_y_i),
    .color_i  (pix_color_i),
    .ovl_a_i  (ovl_a_i),
    .ovl_b_i  (ovl_b_i),
    .hit_i    (hit),
    .pick_b_i (pick_b),
    .valid_o  (pix_valid_o),
    .x_o      (pix_x_o),
    .y_o      (pix_y_o),
    .color_o  (pix_color_o)
  );
endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk #(
  parameter int unsigned COLOR_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         reg_be_i,
  input logic [11:0]        reg_addr_i,
  input logic [31:0]        reg_rdata_o,
  input logic [15:0]        disp_width_i,
  input logic [COLOR_W-1:0] ovl_a_i,
  input logic [COLOR_W-1:0] ovl_b_i,
  input logic               pix_valid_i,
  input logic [15:0]        pix_x_i,
  input logic [15:0]        pix_y_i,
  input logic [COLOR_W-1:0] pix_color_i,
  input logic               pix_valid_o,
  input logic [15:0]        pix_x_o,
  input logic [15:0]        pix_y_o,
  input logic [COLOR_W-1:0] pix_color_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_carry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (pix_valid_o == $past(pix_valid_i)) && (pix_x_o == $past(pix_x_i)) && (pix_y_o == $past(pix_y_i)));

  p_clip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    $past(pix_x_i >= disp_width_i) |-> (pix_color_o == $past(pix_color_i)));

  p_only_ovl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (pix_color_o != $past(pix_color_i)) |-> (pix_color_o == $past(ovl_a_i) || pix_color_o == $past(ovl_b_i)));

  p_misc_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_be_i == 4'hF && reg_addr_i == 12'h818) |-> reg_rdata_o[25]);

  p_other_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != 12'h818) |-> (reg_rdata_o == 32'h0));

  p_partial_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_be_i != 4'hF) |-> (reg_rdata_o == 32'h0));
endmodule

bind cur_overlay cur_overlay_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_be_i     (reg_be_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .disp_width_i (disp_width_i),
  .ovl_a_i      (ovl_a_i),
  .ovl_b_i      (ovl_b_i),
  .pix_valid_i  (pix_valid_i),
  .pix_x_i      (pix_x_i),
  .pix_y_i      (pix_y_i),
  .pix_color_i  (pix_color_i),
  .pix_valid_o  (pix_valid_o),
  .pix_x_o      (pix_x_o),
  .pix_y_o      (pix_y_o),
  .pix_color_o  (pix_color_o)
);

// File: tb/tb_cur_overlay.sv
`timescale 1ns/1ps
module tb_cur_overlay;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    be = 4'hF;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [15:0]   width = 16'd64;
  logic [CW-1:0] ca = 24'h00FF00, cb = 24'hFF00FF;
  logic          pv = 1'b0;
  logic [15:0]   px = '0, py = '0;
  logic [CW-1:0] pc = '0;
  logic          ov;
  logic [15:0]   ox, oy;
  logic [CW-1:0] oc;

  always #10 clk = ~clk;

  cur_overlay #(.COLOR_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_be_i(be), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .disp_width_i(width),
    .ovl_a_i(ca), .ovl_b_i(cb), .pix_valid_i(pv), .pix_x_i(px), .pix_y_i(py),
    .pix_color_i(pc), .pix_valid_o(ov), .pix_x_o(ox), .pix_y_o(oy), .pix_color_o(oc)
  );

  // behavioural reference model
  logic [31:0]   m_mask [32];
  logic [31:0]   m_sel  [32];
  int            m_cx, m_cy;
  logic [31:0]   m_misc;
  logic          e_v;
  logic [15:0]   e_x, e_y;
  logic [CW-1:0] e_c;

  int checks = 0, fails = 0;
  string tag = "R1";

  function automatic logic [CW-1:0] model_pix(int x, int y, logic [CW-1:0] base);
    int dx = x - m_cx;
    int dy = y - m_cy;
    if (x < int'(width) && dx >= 0 && dx < 32 && dy >= 0 && dy < 32 && m_mask[dy][31-dx])
      return m_sel[dy][31-dx] ? cb : ca;
    return base;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 32; r++) begin m_mask[r] = '0; m_sel[r] = '0; end
      m_cx = 'hF000; m_cy = 'hF000; m_misc = '0;
      e_v = 0; e_x = '0; e_y = '0; e_c = '0;
    end else begin
      e_v = pv; e_x = px; e_y = py;
      e_c = model_pix(int'(px), int'(py), pc);
      if (we && be == 4'hF) begin
        if (addr == 12'h8FC) begin m_cx = int'(wdata[31:16]); m_cy = int'(wdata[15:0]); end
        else if (addr == 12'h818) m_misc = wdata;
        else if (addr >= 12'h900 && addr < 12'h980) m_mask[(addr - 12'h900) >> 2] = wdata;
        else if (addr >= 12'h980 && addr < 12'hA00) m_sel[(addr - 12'h980) >> 2] = wdata;
      end
    end
  end

  task automatic check_now();
    logic [31:0] er;
    er = (be == 4'hF && addr == 12'h818) ? (m_misc | 32'h0200_0000) : 32'h0;
    checks++;
    if (ov !== e_v || ox !== e_x || oy !== e_y || oc !== e_c) begin
      fails++;
      $display("FAIL %s pixel: got v=%0b x=%0d y=%0d c=%h, expected v=%0b x=%0d y=%0d c=%h",
               tag, ov, ox, oy, oc, e_v, e_x, e_y, e_c);
    end
    checks++;
    if (rdata !== er) begin
      fails++;
      $display("FAIL %s rdata at %h: got %h, expected %h", tag, addr, rdata, er);
    end
  endtask

  // check the previous cycle's outputs, then drive the next inputs
  task automatic step(logic v, int x, int y, logic [CW-1:0] c);
    @(negedge clk);
    check_now();
    we = 1'b0; pv = v; px = 16'(x); py = 16'(y); pc = c;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    check_now();
    we = 1'b1; addr = a; wdata = d; be = b; pv = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [3:0] b);
    @(negedge clk);
    check_now();
    we = 1'b0; addr = a; be = b;
  endtask

  task automatic scan(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        step(((x + y) % 7) != 0, x, y, CW'((x * 24'h010203) ^ (y * 24'h0A0B0C)));
  endtask

  initial begin
    #400_000_000;
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: parked cursor, misc reset value
    tag = "R1";
    rd(12'h818, 4'hF);
    scan(0, 7, 0, 3);
    // R3: load shape rows; R4/R5 checked by scan
    tag = "R3";
    for (int r = 0; r < 32; r++) begin
      wr(12'h900 + 12'(4*r), (r == 31) ? 32'hFFFF_FFFF : (32'(r) * 32'h9E37_79B1) ^ 32'hF0F0_0F0F, 4'hF);
      wr(12'h980 + 12'(4*r), (r == 31) ? 32'hAAAA_AAAA : (32'(r) * 32'h85EB_CA6B) ^ 32'h0FF0_F00F, 4'hF);
    end
    tag = "R2";
    wr(12'h8FC, {16'd10, 16'd5}, 4'hF);
    tag = "R4";
    scan(6, 45, 3, 38);
    tag = "R5";
    scan(10, 41, 36, 36);
    // R6: straddle right edge, then fully past edge
    tag = "R6";
    wr(12'h8FC, {16'd50, 16'd2}, 4'hF);
    scan(44, 70, 2, 8);
    wr(12'h8FC, {16'd64, 16'd2}, 4'hF);
    scan(60, 90, 2, 6);
    // R9: partial writes ignored
    tag = "R9";
    wr(12'h8FC, {16'd0, 16'd0}, 4'h3);
    wr(12'h904, 32'h0, 4'h7);
    wr(12'h818, 32'hFFFF_FFFF, 4'hE);
    wr(12'h8FC, {16'd20, 16'd20}, 4'hF);
    tag = "R9";
    scan(18, 30, 20, 22);
    rd(12'h818, 4'h1);
    rd(12'h818, 4'hF);
    // R7: misc store and forced bit
    tag = "R7";
    wr(12'h818, 32'h00AB_CDEF, 4'hF);
    rd(12'h818, 4'hF);
    wr(12'h818, 32'hFDFF_FFFF, 4'hF);
    rd(12'h818, 4'hF);
    // R8: other offsets read 0
    tag = "R8";
    rd(12'h8FC, 4'hF); rd(12'h900, 4'hF); rd(12'h9FC, 4'hF); rd(12'h000, 4'hF);
    // R11: same-cycle write uses old position, next cycle uses new
    tag = "R11";
    @(negedge clk); check_now();
    we = 1'b1; addr = 12'h8FC; wdata = {16'd200, 16'd200}; be = 4'hF;
    pv = 1'b1; px = 16'd20; py = 16'd50; pc = 24'h123456;
    step(1'b1, 20, 50, 24'h123456);
    step(1'b1, 21, 51, 24'h654321);
    // R10: valid low and coordinates carried
    tag = "R10";
    wr(12'h8FC, {16'd0, 16'd0}, 4'hF);
    for (int i = 0; i < 40; i++) step(i[0], i, i / 3, CW'(i * 24'h111111));
    step(1'b0, 0, 0, '0);
    step(1'b0, 0, 0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule